// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Result Guard

This block sequences an A/D converter. It decides when a conversion begins, tracks the conversion until it ends, and holds the result in a register. A transfer service reads that register and moves each result to memory. Software writes a small control word. That word selects whether the external trigger pin may start a conversion, issues software starts, enables the transfer-service mode and clears a sticky pause flag. A down-counter models the conversion time and produces the end-of-conversion event.

When the transfer-service mode is on, each latched result raises a request, and the service's acknowledge retires that request. A conversion may finish while the request for the previous result is still open. In that case the block does not overwrite the result register. It parks the new sample in a holding register, stays busy, enters a pause and sets the pause flag. The service then acknowledges the old result. The block loads the parked sample into the result register, raises a fresh request and goes idle, all in one cycle. A software start during the pause also ends it, but it abandons the parked sample and begins a new conversion.

Top module: `sar_seq`

## Requirements
- R1: After reset, `busy`, `pause_flag`, `res_req` and `conv_start` are 0 and `result` is 0. The control readback `ctrl_rdata` is 6'b000011.
- R2: A control write with bit 1 (start) set while idle has two effects at the next clock edge: `conv_start` pulses for exactly one cycle and `busy` rises. The result is latched and `busy` falls CONV_CYCLES edges after that. A write with bit 1 clear starts nothing.
- R3: Bits 3:2 of the control word are the trigger select. Bit 2 (codes 01 and 11) enables the pin trigger in addition to software start. With bit 2 clear (codes 00 and 10), only software starts conversions and pin activity is ignored.
- R4: With the pin trigger enabled, a falling edge on `trig_n` starts a conversion. The pin passes through a two-flop synchronizer, so `busy` and `conv_start` are high three edges after the pin falls. A rising edge starts nothing. Pin and software triggers are accepted on a first-come basis.
- R5: Any start trigger, from software or the pin, that arrives while `busy` is high outside a pause is ignored.
- R6: Suppose the transfer-service mode (bit 5) is on and `res_req` is still high, with no acknowledge in that cycle, when a conversion ends. Then `result` keeps its value, `busy` stays high, the block pauses and `pause_flag` (readback bit 4) becomes 1.
- R7: An acknowledge during a pause has three effects in that cycle: the parked sample is loaded into `result`, `res_req` is held at 1 for the new result, and `busy` falls.
- R8: A software start during a pause ends the pause without changing `result`. It also pulses `conv_start` and begins a fresh conversion.
- R9: `pause_flag` stays 1 after the pause ends. Only a control write with bit 4 clear resets it, and a write with bit 4 set leaves it unchanged.
- R10: With the transfer-service mode off, every end of conversion overwrites `result`. In that mode `res_req` stays 0, no pause occurs and `pause_flag` never sets.
- R11: Readback bit 0 always reads 1, and writes to it have no effect. Readback bit 1 reads 1 on a plain read and 0 when `rd_rmw` is high.
- R12: Outside a pause, an acknowledge clears `res_req` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 6 | Control word: [5] transfer mode, [4] pause flag (write 0 clears), [3:2] trigger select, [1] start, [0] fixed |
| rd_rmw | input | 1 | Current read is part of a read-modify-write |
| ctrl_rdata | output | 6 | Control word readback |
| trig_n | input | 1 | External trigger pin, active on its falling edge |
| conv_data | input | DATA_W | Sample value presented at end of conversion |
| xfer_ack | input | 1 | Transfer service has moved the current result |
| busy | output | 1 | Conversion in progress or stalled |
| pause_flag | output | 1 | Sticky pause indication |
| conv_start | output | 1 | One-cycle pulse at each conversion start |
| res_req | output | 1 | Result waiting for the transfer service |
| result | output | DATA_W | Held conversion result |

## Verification
The hardest situation to reach from the ports is a software start that lands while the block is paused and the old result is still unacknowledged. To get there, the bench completes one conversion in transfer mode and leaves it unacknowledged. It then starts a second conversion so that the block stalls, and while stalled it writes the start bit again. The restarted conversion then stalls a second time behind the same pending request. The final acknowledge must therefore deliver the third sample rather than the abandoned second one.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int CTRL_W    = 6;
  localparam int BIT_ONE   = 0;
  localparam int BIT_GO    = 1;
  localparam int BIT_TSEL0 = 2;
  localparam int BIT_TSEL1 = 3;
  localparam int BIT_PFLAG = 4;
  localparam int BIT_XEN   = 5;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end
  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/seq_pin_fall.sv
module seq_pin_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

  assert_fall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/seq_conv_timer.sv
module seq_conv_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic eoc_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active_q, active_d;

  assign eoc_o = active_q && (cnt_q == '0);

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    if (start_i) begin
      active_d = 1'b1;
      cnt_d    = CNT_W'(CYCLES - 1);
    end else if (eoc_o) begin
      active_d = 1'b0;
    end else if (active_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end

  assert_eoc_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_o && !start_i) |=> !eoc_o);
endmodule

// File: rtl/seq_result_guard.sv
module seq_result_guard #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              xen_i,
  input  logic              ack_i,
  input  logic              sw_go_i,
  input  logic              pf_clr_i,
  output logic              busy_o,
  output logic              paused_o,
  output logic              pflag_o,
  output logic              req_o,
  output logic [DATA_W-1:0] result_o
);
  logic              busy_q, busy_d;
  logic              paused_q, paused_d;
  logic              pflag_q, pflag_d;
  logic              req_q, req_d;
  logic [DATA_W-1:0] result_q, result_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              pf_set;

  always_comb begin
    busy_d   = busy_q;
    paused_d = paused_q;
    req_d    = req_q;
    result_d = result_q;
    hold_d   = hold_q;
    pf_set   = 1'b0;
    if (paused_q) begin
      if (sw_go_i) begin
        paused_d = 1'b0;
      end else if (ack_i) begin
        paused_d = 1'b0;
        result_d = hold_q;
        req_d    = 1'b1;
        busy_d   = 1'b0;
      end
    end else begin
      if (ack_i && req_q) req_d = 1'b0;
      if (eoc_i) begin
        if (xen_i && req_q && !ack_i) begin
          paused_d = 1'b1;
          hold_d   = data_i;
          pf_set   = 1'b1;
        end else begin
          result_d = data_i;
          req_d    = xen_i;
          busy_d   = 1'b0;
        end
      end
    end
    if (start_i) busy_d = 1'b1;
    pflag_d = pflag_q;
    if (pf_clr_i) pflag_d = 1'b0;
    if (pf_set)   pflag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      paused_q <= 1'b0;
      pflag_q  <= 1'b0;
      req_q    <= 1'b0;
      result_q <= '0;
      hold_q   <= '0;
    end else begin
      busy_q   <= busy_d;
      paused_q <= paused_d;
      pflag_q  <= pflag_d;
      req_q    <= req_d;
      result_q <= result_d;
      hold_q   <= hold_d;
    end
  end

  assign busy_o   = busy_q;
  assign paused_o = paused_q;
  assign pflag_o  = pflag_q;
  assign req_o    = req_q;
  assign result_o = result_q;

  assert_pause_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    paused_q |-> busy_q);
  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_q && !ack_i) |=> $stable(result_q));
  assert_resume_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_q && ack_i && !sw_go_i && !start_i) |=> (req_q && !busy_q));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pflag_q && !pf_clr_i) |=> pflag_q);
  assert_flag_needs_xen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pflag_q) |-> $past(xen_i));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int CONV_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [5:0]        wr_data,
  input  logic              rd_rmw,
  output logic [5:0]        ctrl_rdata,
  input  logic              trig_n,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              xfer_ack,
  output logic              busy,
  output logic              pause_flag,
  output logic              conv_start,
  output logic              res_req,
  output logic [DATA_W-1:0] result
);
  logic       rst_n_i;
  logic       pin_fall, eoc, paused;
  logic [1:0] tsel_q, tsel_d;
  logic       xen_q, xen_d;
  logic       start_q;
  logic       sw_go, pin_go, start_go, resume_go, tmr_start, pf_clr;

  seq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  seq_pin_fall #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n_i), .pin_i(trig_n), .fall_o(pin_fall));

  // Trigger arbitration: first trigger while idle wins.
  assign sw_go     = wr_en & wr_data[BIT_GO];
  assign pin_go    = tsel_q[0] & pin_fall;
  assign start_go  = !busy & (sw_go | pin_go);
  assign resume_go = paused & sw_go;
  assign tmr_start = start_go | resume_go;
  assign pf_clr    = wr_en & !wr_data[BIT_PFLAG];

  seq_conv_timer #(.CYCLES(CONV_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n_i), .start_i(tmr_start), .eoc_o(eoc));

  seq_result_guard #(.DATA_W(DATA_W)) u_guard (
    .clk(clk), .rst_n(rst_n_i), .start_i(tmr_start), .eoc_i(eoc),
    .data_i(conv_data), .xen_i(xen_q), .ack_i(xfer_ack),
    .sw_go_i(sw_go), .pf_clr_i(pf_clr), .busy_o(busy),
    .paused_o(paused), .pflag_o(pause_flag), .req_o(res_req),
    .result_o(result));

  always_comb begin
    tsel_d = tsel_q;
    xen_d  = xen_q;
    if (wr_en) begin
      tsel_d = wr_data[BIT_TSEL1:BIT_TSEL0];
      xen_d  = wr_data[BIT_XEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tsel_q  <= 2'b00;
      xen_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      tsel_q  <= tsel_d;
      xen_q   <= xen_d;
      start_q <= tmr_start;
    end
  end

  assign conv_start = start_q;
  assign ctrl_rdata = {xen_q, pause_flag, tsel_q, ~rd_rmw, 1'b1};

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    conv_start |=> !conv_start);
  assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    conv_start |-> busy);
  assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy && !paused) |=> !conv_start);
endmodule

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  localparam int DW = 10;
  localparam int N  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [5:0]    wr_data = '0;
  logic          rd_rmw = 1'b0;
  logic [5:0]    ctrl_rdata;
  logic          trig_n = 1'b1;
  logic [DW-1:0] conv_data = '0;
  logic          xfer_ack = 1'b0;
  logic          busy, pause_flag, conv_start, res_req;
  logic [DW-1:0] result;

  int nchk = 0, nerr = 0, nstart = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sar_seq #(.DATA_W(DW), .CONV_CYCLES(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_rmw(rd_rmw), .ctrl_rdata(ctrl_rdata), .trig_n(trig_n),
    .conv_data(conv_data), .xfer_ack(xfer_ack), .busy(busy),
    .pause_flag(pause_flag), .conv_start(conv_start), .res_req(res_req),
    .result(result));

  always @(posedge clk) if (conv_start) nstart++;

  // Table entries: {trigger select[1:0], use pin, starts expected}
  localparam logic [3:0] VEC [8] = '{
    4'b00_1_0, 4'b00_0_1, 4'b01_1_1, 4'b01_0_1,
    4'b10_1_0, 4'b10_0_1, 4'b11_1_1, 4'b11_0_1};

  function automatic logic [5:0] w(input logic xen, input logic pf,
                                   input logic [1:0] ts, input logic go);
    return {xen, pf, ts, go, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); xfer_ack = 1'b1;
    @(negedge clk); xfer_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 pause_flag", pause_flag, 0);
    chk("R1 res_req", res_req, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 result", result, 0);
    chk("R1 rdata", ctrl_rdata, 6'b000011);

    // R3 table walk: trigger select against pin and software triggers
    for (int i = 0; i < 8; i++) begin
      wr(w(0, 1, VEC[i][3:2], 0));
      base = nstart;
      if (VEC[i][1]) begin
        @(negedge clk); trig_n = 1'b0;
        idle(N + 6);
        trig_n = 1'b1;
        idle(4);
      end else begin
        wr(w(0, 1, VEC[i][3:2], 1));
        idle(N + 3);
      end
      chk("R3 start count", nstart - base, {31'd0, VEC[i][0]});
      chk("R3 idle after", busy, 0);
    end

    // R2 software start timing; write with start clear does nothing
    base = nstart;
    wr(w(0, 1, 2'b00, 0));
    idle(3);
    chk("R2 no start on 0", nstart - base, 0);
    conv_data = 10'h1C7;
    wr(w(0, 1, 2'b00, 1));
    chk("R2 pulse", conv_start, 1);
    chk("R2 busy rise", busy, 1);
    @(negedge clk);
    chk("R2 pulse one cycle", conv_start, 0);
    idle(N - 2);
    chk("R2 busy before end", busy, 1);
    @(negedge clk);
    chk("R2 busy falls", busy, 0);
    chk("R2 result", result, 10'h1C7);
    chk("R10 no req when xfer off", res_req, 0);

    // R4 pin latency through synchronizer
    wr(w(0, 1, 2'b01, 0));
    @(negedge clk); trig_n = 1'b0;
    idle(2);
    chk("R4 not yet busy", busy, 0);
    @(negedge clk);
    chk("R4 busy after sync", busy, 1);
    chk("R4 pulse", conv_start, 1);
    idle(N + 2);
    base = nstart;
    trig_n = 1'b1;
    idle(6);
    chk("R4 rising edge ignored", nstart - base, 0);

    // R5 triggers while busy ignored
    base = nstart;
    wr(w(0, 1, 2'b01, 1));
    idle(2);
    wr(w(0, 1, 2'b01, 1));
    @(negedge clk); trig_n = 1'b0;
    idle(N + 3);
    trig_n = 1'b1;
    idle(3);
    chk("R5 single start", nstart - base, 1);

    // R6/R7/R9/R12 overwrite protection with transfer mode on
    conv_data = 10'h11A;
    wr(w(1, 1, 2'b00, 1));
    idle(N);
    chk("R6 first result", result, 10'h11A);
    chk("R6 req up", res_req, 1);
    conv_data = 10'h2B5;
    wr(w(1, 1, 2'b00, 1));
    idle(N);
    chk("R6 stalled busy", busy, 1);
    chk("R6 pause flag", pause_flag, 1);
    chk("R6 readback flag", ctrl_rdata[4], 1);
    idle(3);
    chk("R6 result kept", result, 10'h11A);
    ack();
    chk("R7 parked result", result, 10'h2B5);
    chk("R7 new request", res_req, 1);
    chk("R7 busy low", busy, 0);
    chk("R9 flag sticky", pause_flag, 1);
    wr(w(1, 1, 2'b00, 0));
    chk("R9 write 1 keeps", pause_flag, 1);
    wr(w(1, 0, 2'b00, 0));
    chk("R9 write 0 clears", pause_flag, 0);
    ack();
    chk("R12 ack clears req", res_req, 0);

    // R8 software start during a pause
    conv_data = 10'h0F0;
    wr(w(1, 1, 2'b00, 1));
    idle(N);
    conv_data = 10'h155;
    wr(w(1, 1, 2'b00, 1));
    idle(N);
    chk("R8 paused busy", busy, 1);
    conv_data = 10'h3C3;
    base = nstart;
    wr(w(1, 1, 2'b00, 1));
    chk("R8 restart pulse", conv_start, 1);
    chk("R8 result kept", result, 10'h0F0);
    idle(N + 2);
    chk("R8 one restart", nstart - base, 1);
    chk("R8 stalls again", busy, 1);
    ack();
    chk("R8 delivers newest", result, 10'h3C3);
    ack();
    chk("R12 req cleared", res_req, 0);

    // R10 transfer mode off: overwrite, no pause
    wr(w(0, 0, 2'b00, 0));
    conv_data = 10'h0AA;
    wr(w(0, 1, 2'b00, 1));
    idle(N);
    conv_data = 10'h155;
    wr(w(0, 1, 2'b00, 1));
    idle(N);
    chk("R10 overwrite", result, 10'h155);
    chk("R10 idle", busy, 0);
    chk("R10 no flag", pause_flag, 0);
    chk("R10 no req", res_req, 0);

    // R11 readback
    @(negedge clk); wr_en = 1'b1; wr_data = 6'b000100;
    @(negedge clk); wr_en = 1'b0;
    chk("R11 bit0 fixed", ctrl_rdata[0], 1);
    chk("R11 plain read", ctrl_rdata[1], 1);
    rd_rmw = 1'b1;
    #1;
    chk("R11 rmw read", ctrl_rdata[1], 0);
    rd_rmw = 1'b0;
    idle(N + 3);

    finish_run();
  end
endmodule